// File: doc/BRIEF.md
# Backplane Interrupt Level Selector with Acknowledge Cycle Control

This block watches one of seven active-low backplane interrupt request lines and turns it into a single host interrupt. A three-bit level field picks the line to watch. Each request line first passes through a two-flop synchronizer. The host interrupt output follows the OR of three sources: the watched line while interrupts are enabled, a software-forced request, and, as a configuration option, the sticky bus-error flag. A status flag shows whether the watched line is asserted at the moment.

When the host reads the acknowledge port, the block asks the bus sequencer for an interrupt-acknowledge cycle. It presents the level code that the sequencer drives onto address lines A03..A01. It then captures the vector the sequencer returns and hands it back to the host. The width of the vector follows the width of the host access. A narrow read returns only the low byte. A wide read returns the vector in bits 7..0 and the reason code in bits 15..8. When no level is selected, the read completes at once with zero and no bus cycle starts.

Top module: `irq_level_ack`

## Requirements
- R1: Level code 0 on `lvl_sel` selects no line. Code k in 1..7 selects request input `req_n[k-1]`, which is backplane level k.
- R2: `line_flag` is 1 exactly when the selected line is low after synchronization. It is 0 whenever `lvl_sel` is 0.
- R3: `host_irq` equals (`line_flag` AND `int_en`) OR `soft_int` OR (`berr_int_en` AND `berr_flag`). It is combinational in these terms, so it falls in the same cycle that the last active source falls.
- R4: While `berr_int_en` is 0, `berr_flag` has no effect on `host_irq`.
- R5: A cycle with `ack_rd` high and a non-zero `lvl_sel` raises `iack_req` from the next cycle onward. `iack_lvl` holds that level code and `iack_wide` holds `ack_wide`. Both stay unchanged until the cycle in which `iack_done` is sampled high.
- R6: The cycle after `iack_done` is sampled, `ack_rvalid` pulses for one cycle and `iack_req` is low. With `iack_wide`=1, `ack_rdata` equals the full 16-bit `iack_data` (vector in 7..0, reason in 15..8). With `iack_wide`=0, `ack_rdata` is `iack_data[7:0]` with bits 15..8 zero.
- R7: A cycle with `ack_rd` high and `lvl_sel`=0 gives `ack_rvalid`=1 with `ack_rdata`=0 in the next cycle. `iack_req` stays low.
- R8: `ack_rd` is ignored while an acknowledge request is outstanding. The level and width already presented do not change, and no extra `ack_rvalid` follows.
- R9: A change on a request input reaches `line_flag` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_n | input | 7 | Backplane interrupt requests, active low; bit k-1 is level k |
| lvl_sel | input | 3 | Monitored level code, 0 = none |
| int_en | input | 1 | Enables the monitored line as an interrupt source |
| soft_int | input | 1 | Software-forced interrupt |
| berr_flag | input | 1 | Sticky bus-error flag |
| berr_int_en | input | 1 | Lets the bus-error flag raise the interrupt |
| line_flag | output | 1 | Selected line currently asserted |
| host_irq | output | 1 | Level-sensitive host interrupt |
| ack_rd | input | 1 | Host read strobe of the acknowledge port |
| ack_wide | input | 1 | Host access is 16-bit (1) or 8-bit (0) |
| ack_rvalid | output | 1 | Read data valid pulse |
| ack_rdata | output | 16 | Returned vector |
| iack_req | output | 1 | Request to sequencer for an acknowledge cycle |
| iack_lvl | output | 3 | Level code for address lines A03..A01 |
| iack_wide | output | 1 | Requested vector width to sequencer |
| iack_done | input | 1 | Sequencer finished the acknowledge cycle |
| iack_data | input | 16 | Data captured by the sequencer |

## Verification
The assertions assume three things about the environment. The sequencer pulses `iack_done` only while `iack_req` is high. The host issues at most one read strobe per cycle. `lvl_sel` stays steady from the acknowledge strobe until that read completes. The stimulus holds `iack_done` low except for a single cycle after a request has been seen. It changes `lvl_sel` only while idle, except in the deliberate test of a second strobe during a pending request. The request lines, enables and levels are otherwise drawn at random from a fixed seed and are held for enough cycles for the synchronizer to settle before the bench samples.

// File: rtl/irq_level_ack_pkg.sv
package irq_level_ack_pkg;
  typedef enum logic [0:0] {
    ACK_IDLE = 1'b0,
    ACK_WAIT = 1'b1
  } ack_state_t;
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_n,
  output logic [WIDTH-1:0] sync_n
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= async_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int LVL_W = 3,
  localparam int NL   = (1 << LVL_W) - 1
) (
  input  logic [NL-1:0]    sync_n,
  input  logic [LVL_W-1:0] lvl_sel,
  input  logic             int_en,
  input  logic             soft_int,
  input  logic             berr_flag,
  input  logic             berr_int_en,
  output logic             line_flag,
  output logic             host_irq
);
  function automatic logic pick_line(input logic [NL-1:0] rn, input logic [LVL_W-1:0] lvl);
    logic hit;
    hit = 1'b0;
    for (int i = 1; i <= NL; i++) begin
      if (lvl == LVL_W'(i)) hit = !rn[i-1];
    end
    return hit;
  endfunction

  function automatic logic merge_sources(input logic flag, input logic en, input logic sw,
                                         input logic be, input logic be_en);
    return (flag & en) | sw | (be & be_en);
  endfunction

  assign line_flag = pick_line(sync_n, lvl_sel);
  assign host_irq  = merge_sources(line_flag, int_en, soft_int, berr_flag, berr_int_en);
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_level_ack_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int VEC_W = 16,
  localparam int HALF = VEC_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_rd,
  input  logic             ack_wide,
  input  logic [LVL_W-1:0] lvl_sel,
  input  logic             iack_done,
  input  logic [VEC_W-1:0] iack_data,
  output logic             iack_req,
  output logic [LVL_W-1:0] iack_lvl,
  output logic             iack_wide,
  output logic             ack_rvalid,
  output logic [VEC_W-1:0] ack_rdata
);
  ack_state_t st_q;
  logic       ev_start, ev_null, ev_finish;

  function automatic logic [VEC_W-1:0] shape_vec(input logic [VEC_W-1:0] raw, input logic wide);
    return wide ? raw : {{(VEC_W-HALF){1'b0}}, raw[HALF-1:0]};
  endfunction

  assign ev_start  = (st_q == ACK_IDLE) && ack_rd && (lvl_sel != '0);
  assign ev_null   = (st_q == ACK_IDLE) && ack_rd && (lvl_sel == '0);
  assign ev_finish = (st_q == ACK_WAIT) && iack_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ACK_IDLE;
      iack_lvl   <= '0;
      iack_wide  <= 1'b0;
      ack_rvalid <= 1'b0;
      ack_rdata  <= '0;
    end else begin
      ack_rvalid <= ev_null | ev_finish;
      if (ev_start) begin
        st_q      <= ACK_WAIT;
        iack_lvl  <= lvl_sel;
        iack_wide <= ack_wide;
      end
      if (ev_null) begin
        ack_rdata <= '0;
      end
      if (ev_finish) begin
        st_q      <= ACK_IDLE;
        ack_rdata <= shape_vec(iack_data, iack_wide);
      end
    end
  end

  assign iack_req = (st_q == ACK_WAIT);
endmodule

// File: rtl/irq_level_ack.sv
module irq_level_ack #(
  parameter int LVL_W       = 3,
  parameter int VEC_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NL         = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NL-1:0]    req_n,
  input  logic [LVL_W-1:0] lvl_sel,
  input  logic             int_en,
  input  logic             soft_int,
  input  logic             berr_flag,
  input  logic             berr_int_en,
  output logic             line_flag,
  output logic             host_irq,
  input  logic             ack_rd,
  input  logic             ack_wide,
  output logic             ack_rvalid,
  output logic [VEC_W-1:0] ack_rdata,
  output logic             iack_req,
  output logic [LVL_W-1:0] iack_lvl,
  output logic             iack_wide,
  input  logic             iack_done,
  input  logic [VEC_W-1:0] iack_data
);
  logic [NL-1:0] req_sync_n;

  irq_req_sync #(.WIDTH(NL), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (req_n),
    .sync_n  (req_sync_n)
  );

  irq_level_pick #(.LVL_W(LVL_W)) u_pick (
    .sync_n      (req_sync_n),
    .lvl_sel     (lvl_sel),
    .int_en      (int_en),
    .soft_int    (soft_int),
    .berr_flag   (berr_flag),
    .berr_int_en (berr_int_en),
    .line_flag   (line_flag),
    .host_irq    (host_irq)
  );

  irq_ack_ctrl #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_rd     (ack_rd),
    .ack_wide   (ack_wide),
    .lvl_sel    (lvl_sel),
    .iack_done  (iack_done),
    .iack_data  (iack_data),
    .iack_req   (iack_req),
    .iack_lvl   (iack_lvl),
    .iack_wide  (iack_wide),
    .ack_rvalid (ack_rvalid),
    .ack_rdata  (ack_rdata)
  );
endmodule

// File: rtl/irq_level_ack_chk.sv
module irq_level_ack_chk #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] lvl_sel,
  input logic             int_en,
  input logic             soft_int,
  input logic             berr_flag,
  input logic             berr_int_en,
  input logic             line_flag,
  input logic             host_irq,
  input logic             ack_rd,
  input logic             ack_rvalid,
  input logic [VEC_W-1:0] ack_rdata,
  input logic             iack_req,
  input logic [LVL_W-1:0] iack_lvl,
  input logic             iack_wide,
  input logic             iack_done
);
  assert_none_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_sel == '0) |-> !line_flag);

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !soft_int && !berr_int_en) |-> !host_irq);

  assert_soft_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_int |-> host_irq);

  assert_berr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_int_en && berr_flag) |-> host_irq);

  assert_req_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |-> (iack_lvl != '0));

  assert_req_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_req) |-> $past(ack_rd));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_req && !iack_done) |=> (iack_req && $stable(iack_lvl) && $stable(iack_wide)));

  assert_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rvalid && !iack_wide) |-> (ack_rdata[VEC_W-1:VEC_W/2] == '0));

  assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_req && iack_done) |=> (ack_rvalid && !iack_req));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_rvalid && iack_req));
endmodule

bind irq_level_ack irq_level_ack_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W)) i_chk (.*);

// File: tb/test_irq_level_ack.sv
module test_irq_level_ack;
  localparam int LVL_W = 3;
  localparam int VEC_W = 16;
  localparam int NL    = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL-1:0]    req_n = '1;
  logic [LVL_W-1:0] lvl_sel = '0;
  logic             int_en = 1'b0, soft_int = 1'b0, berr_flag = 1'b0, berr_int_en = 1'b0;
  logic             line_flag, host_irq;
  logic             ack_rd = 1'b0, ack_wide = 1'b0;
  logic             ack_rvalid;
  logic [VEC_W-1:0] ack_rdata;
  logic             iack_req;
  logic [LVL_W-1:0] iack_lvl;
  logic             iack_wide;
  logic             iack_done = 1'b0;
  logic [VEC_W-1:0] iack_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_level_ack i_irq_level_ack (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_flag(input logic [NL-1:0] rn, input int lvl);
    if (lvl < 1 || lvl > NL) return 0;
    return (rn[lvl-1] == 1'b0) ? 1 : 0;
  endfunction

  function automatic int exp_irq(input int flag, input int en, input int sw, input int be, input int be_en);
    if (sw != 0) return 1;
    if (flag != 0 && en != 0) return 1;
    if (be != 0 && be_en != 0) return 1;
    return 0;
  endfunction

  function automatic int exp_vec(input logic [VEC_W-1:0] raw, input int wide);
    if (wide != 0) return int'(raw);
    return int'(raw) % 256;
  endfunction

  task automatic do_ack(input int lvl, input int wide, input logic [VEC_W-1:0] vec, input bit intrude);
    @(negedge clk);
    lvl_sel  = LVL_W'(lvl);
    ack_wide = wide[0];
    ack_rd   = 1'b1;
    @(negedge clk);
    ack_rd = 1'b0;
    if (lvl == 0) begin
      check("R7 rvalid", int'(ack_rvalid), 1);
      check("R7 rdata", int'(ack_rdata), 0);
      check("R7 no req", int'(iack_req), 0);
      @(negedge clk);
      check("R7 pulse", int'(ack_rvalid), 0);
      return;
    end
    check("R5 req", int'(iack_req), 1);
    check("R1 level", int'(iack_lvl), lvl);
    check("R5 width", int'(iack_wide), wide);
    if (intrude) begin
      lvl_sel  = LVL_W'((lvl % NL) + 1);
      ack_wide = ~wide[0];
      ack_rd   = 1'b1;
      @(negedge clk);
      ack_rd = 1'b0;
      check("R8 level kept", int'(iack_lvl), lvl);
      check("R8 width kept", int'(iack_wide), wide);
      check("R8 no rvalid", int'(ack_rvalid), 0);
    end
    @(negedge clk);
    check("R5 held", int'(iack_req), 1);
    iack_done = 1'b1;
    iack_data = vec;
    @(negedge clk);
    iack_done = 1'b0;
    iack_data = '0;
    check("R6 rvalid", int'(ack_rvalid), 1);
    check("R6 req low", int'(iack_req), 0);
    check("R6 rdata", int'(ack_rdata), exp_vec(vec, wide));
    @(negedge clk);
    check("R6 pulse", int'(ack_rvalid), 0);
    if (intrude) check("R8 no restart", int'(iack_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset flag", int'(line_flag), 0);
    check("R3 reset irq", int'(host_irq), 0);
    check("R5 reset req", int'(iack_req), 0);
    check("R6 reset rvalid", int'(ack_rvalid), 0);

    // R9: two-edge latency, then R3 immediate fall
    lvl_sel = 3'd3;
    int_en  = 1'b1;
    req_n[2] = 1'b0;
    @(negedge clk);
    check("R9 one edge", int'(line_flag), 0);
    @(negedge clk);
    check("R9 two edges", int'(line_flag), 1);
    check("R3 line irq", int'(host_irq), 1);
    int_en = 1'b0;
    #1;
    check("R3 same cycle fall", int'(host_irq), 0);
    // R1: neighbouring line has no effect, level 0 ignores all
    req_n = 7'b1111011 ^ 7'b0000100 ^ 7'b0000010;
    repeat (3) @(negedge clk);
    check("R1 other line", int'(line_flag), 0);
    req_n   = '0;
    lvl_sel = '0;
    repeat (3) @(negedge clk);
    check("R2 none selected", int'(line_flag), 0);
    // R4: berr without option
    int_en = 1'b1; berr_flag = 1'b1; berr_int_en = 1'b0;
    #1;
    check("R4 berr masked", int'(host_irq), 0);
    berr_int_en = 1'b1;
    #1;
    check("R4 berr enabled", int'(host_irq), 1);
    berr_flag = 1'b0; berr_int_en = 1'b0; int_en = 1'b0;
    req_n = '1;

    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      req_n       = NL'($urandom);
      lvl_sel     = LVL_W'($urandom);
      int_en      = 1'($urandom);
      soft_int    = ($urandom % 4) == 0;
      berr_flag   = 1'($urandom);
      berr_int_en = 1'($urandom);
      repeat (3) @(negedge clk);
      check("R2 random flag", int'(line_flag), exp_flag(req_n, int'(lvl_sel)));
      check("R3 random irq", int'(host_irq),
            exp_irq(exp_flag(req_n, int'(lvl_sel)), int'(int_en), int'(soft_int),
                    int'(berr_flag), int'(berr_int_en)));
    end
    soft_int = 1'b0; int_en = 1'b0; berr_flag = 1'b0; berr_int_en = 1'b0;

    do_ack(0, 1, 16'hBEEF, 1'b0);
    do_ack(7, 1, 16'h5AC3, 1'b0);
    do_ack(1, 0, 16'h5AC3, 1'b0);
    do_ack(4, 1, 16'h1234, 1'b1);
    for (int n = 0; n < 40; n++) begin
      do_ack(int'($urandom % 8), int'($urandom % 2), VEC_W'($urandom), ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule